// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block steers a sixteen-input multiplexed ADC front end through a software-programmed list of conversion entries. Each entry names a mux input, a two-bit gain code and a polarity bit, and is written together with the list slot it belongs to. A control word sets the slot where a scan begins and the slot where it ends; the walk between them runs upward and wraps from slot 15 back to slot 0.

Conversions are paced from outside. A convert tick starts one conversion of the current entry, provided the convert gate is open, no conversion is in flight, and the block is not waiting for a scan tick or an external trigger. When the ADC returns a result, the result is pushed into a sample FIFO and the sequencer moves to the next entry. Finishing the end slot completes a scan and raises end-of-scan. With the scan pacer gated, every scan waits for a scan tick. With scan mode off, only the begin slot is converted, and every conversion completes a scan. An optional external-trigger arm delays all conversions until a rising edge on the trigger pin.

Software reads the FIFO and a status word over a small register port. Pointer state can be rewound by a read. The block returns to idle when mode and control are cleared and status is then read.

Top module: `scan_list_seq`

## Requirements
- R1: A write to byte address 0x6 stores an entry in slot wdata[11:8], with mux input wdata[3:0], gain wdata[5:4] and unipolar wdata[7]. While the sequencer sits on that slot, fe_chan, fe_gain and fe_unipolar show those fields.
- R2: Control writes go to address 0x0. wdata[3:0] is the begin slot and wdata[11:8] is the end slot. With scan mode on (mode bit 3, mode written at address 0xE), successive conversions use slots begin, begin+1, … end, counting modulo 16, and then wrap back to begin.
- R3: With scan mode off, every conversion uses the begin slot, and every conversion is an end-of-scan.
- R4: A convert tick starts a conversion only while control bit 12 is set and no conversion is outstanding. A tick at any other time has no effect. adc_start is a one-cycle pulse.
- R5: While control bit 13 is set, a scan starts only after a scan tick. This applies to the first scan after the control write and to every scan after it. Convert ticks between scans are ignored.
- R6: While control bit 15 is set, convert ticks are ignored. A rising edge on ext_trig clears bit 15, and conversions then proceed.
- R7: The status word is read at address 0x2. Bit 15 is 1 while a conversion is outstanding and 0 when it has finished. Bit 13 is the latched end-of-scan. Bit 3 is the overflow flag, bit 2 is FIFO full and bit 1 is FIFO empty. Every other bit reads 0.
- R8: Completion of the end slot produces a one-cycle eos_pulse. eos_pulse coincides with eoc_pulse, and it sets status bit 13 until the next status read.
- R9: A read at address 0x0 returns the oldest FIFO sample and removes it. Samples come out in conversion order.
- R10: A result arriving while the FIFO is full is dropped and sets status bit 3. A status read clears bit 3.
- R11: irq is high when mode bit 1 is set and end-of-scan is latched, or when mode bit 0 is set and a conversion has completed since the last status read.
- R12: A read at address 0xC moves the sequencer back to the begin slot.
- R13: Writing 0 to mode and to control, then reading status, leaves irq low and causes convert ticks to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read may have side effects) |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_rd |
| conv_tick | input | 1 | Convert pacer pulse |
| scan_tick | input | 1 | Scan pacer pulse |
| ext_trig | input | 1 | External start trigger |
| adc_start | output | 1 | Start-conversion pulse to the ADC |
| adc_valid | input | 1 | ADC result valid |
| adc_data | input | 16 | ADC result |
| fe_chan | output | 4 | Mux input selected for the current entry |
| fe_gain | output | 2 | Gain code of the current entry |
| fe_unipolar | output | 1 | Polarity of the current entry |
| eoc_pulse | output | 1 | End of conversion, one cycle |
| eos_pulse | output | 1 | End of scan, one cycle |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle:
- adc_start never lasts longer than one cycle.
- End-of-scan is always a single cycle and always coincides with an end-of-conversion.
- After each ordinary completion, the slot pointer advances by exactly one.
- A pointer rewind lands on the begin slot.
- A push into a full FIFO always leaves the overflow flag set.
- The FIFO never reports full and empty together.

Other behaviour can only be shown by the bench's scenarios:
- the order of entries across a wrap past slot 15;
- ticks that are ignored while a scan waits for its pacer or for the external trigger;
- the order in which samples leave the FIFO;
- clearing of the latched flags by a status read;
- the interrupt combinations.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

  typedef struct packed {
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } scan_entry_t;

  localparam int unsigned ENTRY_W = $bits(scan_entry_t);

  // byte addresses of the register port
  localparam logic [3:0] A_CTRL_FIFO = 4'h0;
  localparam logic [3:0] A_STATUS    = 4'h2;
  localparam logic [3:0] A_LIST      = 4'h6;
  localparam logic [3:0] A_REWIND    = 4'hC;
  localparam logic [3:0] A_MODE      = 4'hE;

  // control word fields
  localparam int unsigned C_TRIG_ARM  = 15;
  localparam int unsigned C_GATE_SCAN = 13;
  localparam int unsigned C_GATE_CONV = 12;

  // mode fields
  localparam int unsigned M_SCAN    = 3;
  localparam int unsigned M_EOS_IRQ = 1;
  localparam int unsigned M_EOC_IRQ = 0;

  // status fields
  localparam int unsigned S_BUSY  = 15;
  localparam int unsigned S_EOS   = 13;
  localparam int unsigned S_OVF   = 3;
  localparam int unsigned S_FULL  = 2;
  localparam int unsigned S_EMPTY = 1;

endpackage

// File: rtl/scanseq_list_ram.sv
module scanseq_list_ram
  import scanseq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  scan_entry_t      wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output scan_entry_t      rd_entry
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  scan_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_idx];

endmodule

// File: rtl/scanseq_pointer.sv
module scanseq_pointer #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] ptr,
  output logic             at_last
);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  assign at_last = (ptr_q == last);

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_idx;
    else if (step) ptr_d = at_last ? first : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/scanseq_fifo.sv
module scanseq_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = do_push ? bump(wp_q) : wp_q;
    rp_d  = do_pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

endmodule

// File: rtl/scan_list_seq.sv
module scan_list_seq
  import scanseq_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              conv_tick,
  input  logic              scan_tick,
  input  logic              ext_trig,
  output logic              adc_start,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  output logic [3:0]        fe_chan,
  output logic [1:0]        fe_gain,
  output logic              fe_unipolar,
  output logic              eoc_pulse,
  output logic              eos_pulse,
  output logic              irq
);

  localparam int unsigned IDX_W = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // register port decode
  logic wr_ctrl, wr_list, wr_mode, rd_fifo, rd_stat, rd_rewind;
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL_FIFO);
  assign wr_list   = bus_wr && (bus_addr == A_LIST);
  assign wr_mode   = bus_wr && (bus_addr == A_MODE);
  assign rd_fifo   = bus_rd && (bus_addr == A_CTRL_FIFO);
  assign rd_stat   = bus_rd && (bus_addr == A_STATUS);
  assign rd_rewind = bus_rd && (bus_addr == A_REWIND);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[14], bus_wdata[6], bus_wdata[2]};

  // control and mode state
  logic [IDX_W-1:0] first_q, first_d, last_q, last_d;
  logic gate_conv_q, gate_conv_d, gate_scan_q, gate_scan_d;
  logic trig_arm_q, trig_arm_d;
  logic scan_en_q, scan_en_d, eos_ie_q, eos_ie_d, eoc_ie_q, eoc_ie_d;

  // sequencing state
  logic busy_q, busy_d, wait_q, wait_d;
  logic eos_flag_q, eos_flag_d, eoc_flag_q, eoc_flag_d, ovf_q, ovf_d;
  logic ext_q, start_q, eoc_q, eos_q;

  // datapath links
  logic [IDX_W-1:0] ptr, eff_last, load_idx;
  logic             at_last, ptr_load;
  logic             trig_edge, accept, done, scan_done;
  logic             fifo_full, fifo_empty;
  logic [DATA_W-1:0] fifo_dout;
  scan_entry_t      cur_entry, new_entry;

  assign new_entry.unipolar = bus_wdata[7];
  assign new_entry.gain     = bus_wdata[5:4];
  assign new_entry.chan     = bus_wdata[3:0];

  assign eff_last  = scan_en_q ? last_q : first_q;
  assign trig_edge = ext_trig && !ext_q;
  assign accept    = conv_tick && gate_conv_q && !busy_q && !wait_q && !trig_arm_q;
  assign done      = adc_valid && busy_q;
  assign scan_done = done && at_last;
  assign ptr_load  = wr_ctrl || rd_rewind;
  assign load_idx  = wr_ctrl ? bus_wdata[3:0] : first_q;

  scanseq_list_ram #(.IDX_W(IDX_W)) u_list (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_en    (wr_list),
    .wr_idx   (bus_wdata[11:8]),
    .wr_entry (new_entry),
    .rd_idx   (ptr),
    .rd_entry (cur_entry)
  );

  scanseq_pointer #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (ptr_load),
    .load_idx (load_idx),
    .step     (done),
    .first    (first_q),
    .last     (eff_last),
    .ptr      (ptr),
    .at_last  (at_last)
  );

  scanseq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_ni),
    .push  (done),
    .din   (adc_data),
    .pop   (rd_fifo),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  // next-state logic
  always_comb begin
    first_d     = first_q;
    last_d      = last_q;
    gate_conv_d = gate_conv_q;
    gate_scan_d = gate_scan_q;
    trig_arm_d  = trig_arm_q;
    if (wr_ctrl) begin
      first_d     = bus_wdata[3:0];
      last_d      = bus_wdata[11:8];
      gate_conv_d = bus_wdata[C_GATE_CONV];
      gate_scan_d = bus_wdata[C_GATE_SCAN];
      trig_arm_d  = bus_wdata[C_TRIG_ARM];
    end else if (trig_edge) begin
      trig_arm_d  = 1'b0;
    end

    scan_en_d = wr_mode ? bus_wdata[M_SCAN]    : scan_en_q;
    eos_ie_d  = wr_mode ? bus_wdata[M_EOS_IRQ] : eos_ie_q;
    eoc_ie_d  = wr_mode ? bus_wdata[M_EOC_IRQ] : eoc_ie_q;

    busy_d = busy_q;
    if (accept)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;

    wait_d = wait_q;
    if (wr_ctrl)                       wait_d = bus_wdata[C_GATE_SCAN];
    else if (rd_rewind)                wait_d = gate_scan_q;
    else if (scan_done && gate_scan_q) wait_d = 1'b1;
    else if (scan_tick)                wait_d = 1'b0;

    eos_flag_d = eos_flag_q;
    if (scan_done)    eos_flag_d = 1'b1;
    else if (rd_stat) eos_flag_d = 1'b0;

    eoc_flag_d = eoc_flag_q;
    if (done)         eoc_flag_d = 1'b1;
    else if (rd_stat) eoc_flag_d = 1'b0;

    ovf_d = ovf_q;
    if (done && fifo_full) ovf_d = 1'b1;
    else if (rd_stat)      ovf_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q     <= '0;
      last_q      <= '0;
      gate_conv_q <= 1'b0;
      gate_scan_q <= 1'b0;
      trig_arm_q  <= 1'b0;
      scan_en_q   <= 1'b0;
      eos_ie_q    <= 1'b0;
      eoc_ie_q    <= 1'b0;
      busy_q      <= 1'b0;
      wait_q      <= 1'b0;
      eos_flag_q  <= 1'b0;
      eoc_flag_q  <= 1'b0;
      ovf_q       <= 1'b0;
      ext_q       <= 1'b0;
      start_q     <= 1'b0;
      eoc_q       <= 1'b0;
      eos_q       <= 1'b0;
    end else begin
      first_q     <= first_d;
      last_q      <= last_d;
      gate_conv_q <= gate_conv_d;
      gate_scan_q <= gate_scan_d;
      trig_arm_q  <= trig_arm_d;
      scan_en_q   <= scan_en_d;
      eos_ie_q    <= eos_ie_d;
      eoc_ie_q    <= eoc_ie_d;
      busy_q      <= busy_d;
      wait_q      <= wait_d;
      eos_flag_q  <= eos_flag_d;
      eoc_flag_q  <= eoc_flag_d;
      ovf_q       <= ovf_d;
      ext_q       <= ext_trig;
      start_q     <= accept;
      eoc_q       <= done;
      eos_q       <= scan_done;
    end
  end

  // read mux
  logic [15:0] status_word;
  always_comb begin
    status_word          = '0;
    status_word[S_BUSY]  = busy_q;
    status_word[S_EOS]   = eos_flag_q;
    status_word[S_OVF]   = ovf_q;
    status_word[S_FULL]  = fifo_full;
    status_word[S_EMPTY] = fifo_empty;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL_FIFO: bus_rdata = 16'(fifo_dout);
        A_STATUS:    bus_rdata = status_word;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign adc_start   = start_q;
  assign fe_chan     = cur_entry.chan;
  assign fe_gain     = cur_entry.gain;
  assign fe_unipolar = cur_entry.unipolar;
  assign eoc_pulse   = eoc_q;
  assign eos_pulse   = eos_q;
  assign irq         = (eos_ie_q && eos_flag_q) || (eoc_ie_q && eoc_flag_q);

endmodule

// File: rtl/scanseq_checker.sv
module scanseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_start,
  input logic       eoc_pulse,
  input logic       eos_pulse,
  input logic       step,
  input logic       at_last,
  input logic       ptr_load,
  input logic       rewind,
  input logic [3:0] ptr,
  input logic [3:0] first,
  input logic       fifo_push,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       ovf
);

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R8
  eos_with_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse |-> eoc_pulse);

  // R8
  eos_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse |=> !eos_pulse);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_last && !ptr_load) |=> (ptr == $past(ptr) + 4'd1));

  // R12
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !step) |=> (ptr == $past(first)));

  // R10
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && fifo_full) |=> ovf);

  // R7
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

endmodule

bind scan_list_seq scanseq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_ni),
  .adc_start  (adc_start),
  .eoc_pulse  (eoc_pulse),
  .eos_pulse  (eos_pulse),
  .step       (done),
  .at_last    (at_last),
  .ptr_load   (ptr_load),
  .rewind     (rd_rewind && !wr_ctrl),
  .ptr        (ptr),
  .first      (first_q),
  .fifo_push  (done),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .ovf        (ovf_q)
);

// File: tb/sim_scan_list_seq.sv
module sim_scan_list_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        conv_tick = 1'b0, scan_tick = 1'b0, ext_trig = 1'b0;
  logic        adc_start, adc_valid;
  logic [15:0] adc_data;
  logic [3:0]  fe_chan;
  logic [1:0]  fe_gain;
  logic        fe_unipolar, eoc_pulse, eos_pulse, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_list_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_tick(conv_tick), .scan_tick(scan_tick), .ext_trig(ext_trig),
    .adc_start(adc_start), .adc_valid(adc_valid), .adc_data(adc_data),
    .fe_chan(fe_chan), .fe_gain(fe_gain), .fe_unipolar(fe_unipolar),
    .eoc_pulse(eoc_pulse), .eos_pulse(eos_pulse), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int eos_cnt = 0;
  bit finished = 0;
  logic [6:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ent(input int i);
    logic [1:0] g;
    logic [3:0] c;
    g = 2'(i % 4);
    c = 4'(15 - i);
    return {i[0], g, c};
  endfunction

  // ADC model: result three cycles after the start pulse, encoding the entry
  logic [1:0]  adc_cnt = '0;
  logic [15:0] adc_hold = '0;
  logic        adc_v = 1'b0;
  assign adc_valid = adc_v;
  assign adc_data  = adc_hold;
  always @(posedge clk) begin
    adc_v <= 1'b0;
    if (adc_start) begin
      adc_cnt  <= 2'd3;
      adc_hold <= {9'd0, fe_unipolar, fe_gain, fe_chan};
    end else if (adc_cnt != 0) begin
      adc_cnt <= adc_cnt - 1'b1;
      if (adc_cnt == 2'd1) adc_v <= 1'b1;
    end
  end

  // monitor: compare front-end selection at each start against the scoreboard
  bit eos_prev = 0;
  always @(negedge clk) begin
    if (rst_n && adc_start) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected start", {25'd0, fe_unipolar, fe_gain, fe_chan}, 0);
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        check({fe_unipolar, fe_gain, fe_chan} == e, "R1/R2 entry at start",
              {fe_unipolar, fe_gain, fe_chan}, e);
      end
    end
    if (eos_pulse) begin
      eos_cnt++;
      if (eos_prev) check(0, "R8 eos width", 2, 1);
    end
    eos_prev = eos_pulse;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); conv_tick = 1'b1;
    @(negedge clk); conv_tick = 1'b0;
  endtask

  task automatic stick();
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
  endtask

  task automatic conv(input int idx);
    exp_q.push_back(ent(idx));
    tick();
    repeat (8) @(negedge clk);
  endtask

  task automatic tick_ignored(input string req);
    logic [15:0] s;
    tick();
    rd(4'h2, s);
    check(s[15] == 1'b0, req, s[15], 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic drain();
    logic [15:0] s, d;
    for (int k = 0; k < 20; k++) begin
      rd(4'h2, s);
      if (s[1]) break;
      rd(4'h0, d);
    end
  endtask

  task automatic fifo_expect(input int idx, input string req);
    logic [15:0] d;
    rd(4'h0, d);
    check(d == {9'd0, ent(idx)}, req, d, {9'd0, ent(idx)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(4'h2, s);
    check(s == 16'h0002, "R7 reset status", s, 16'h0002);
    check(irq == 1'b0, "R11 reset irq", irq, 0);

    // R1: load every slot
    for (int i = 0; i < 16; i++)
      wr(4'h6, 16'((i << 8) | (i[0] << 7) | ((i % 4) << 4) | (15 - i)));

    // R4: convert gate closed
    tick_ignored("R4 tick without gate");

    // R2 basic walk 1..3 with eos irq
    wr(4'hE, 16'h000A);
    wr(4'h0, 16'h1301);
    e0 = eos_cnt;
    conv(1); conv(2);
    // R4: second tick while busy is dropped (monitor flags extra start)
    exp_q.push_back(ent(3));
    tick(); tick();
    repeat (8) @(negedge clk);
    check(eos_cnt - e0 == 1, "R8 one eos per scan", eos_cnt - e0, 1);
    check(irq == 1'b1, "R11 eos irq", irq, 1);
    rd(4'h2, s);
    check(s == 16'h2000, "R7 status after scan", s, 16'h2000);
    check(irq == 1'b0, "R11 irq cleared", irq, 0);
    rd(4'h2, s);
    check(s[13] == 1'b0, "R8 eos cleared", s[13], 0);
    fifo_expect(1, "R9 fifo order");
    fifo_expect(2, "R9 fifo order");
    fifo_expect(3, "R9 fifo order");
    conv(1);  // R2 wrap to begin
    drain();

    // R2 wrap through slot 15
    wr(4'h0, 16'h110E);
    conv(14); conv(15); conv(0); conv(1);
    rd(4'h2, s);
    check(s[13] == 1'b1, "R2 scan complete after wrap", s[13], 1);
    drain();

    // R12 rewind
    wr(4'h0, 16'h1502);
    conv(2); conv(3);
    rd(4'hC, s);
    conv(2); conv(3);
    drain();

    // R3 scan mode off
    wr(4'hE, 16'h0000);
    wr(4'h0, 16'h1905);
    e0 = eos_cnt;
    conv(5); conv(5);
    check(eos_cnt - e0 == 2, "R3 eos every conversion", eos_cnt - e0, 2);
    drain();

    // R5 scan pacer
    wr(4'hE, 16'h0008);
    wr(4'h0, 16'h3100);
    tick_ignored("R5 waiting for first scan tick");
    stick();
    conv(0); conv(1);
    tick_ignored("R5 waiting between scans");
    stick();
    conv(0);
    drain();

    // R6 external trigger
    wr(4'hE, 16'h0000);
    wr(4'h0, 16'h9707);
    tick_ignored("R6 trigger armed");
    @(negedge clk); ext_trig = 1'b1;
    conv(7);
    @(negedge clk); ext_trig = 1'b0;
    conv(7);
    drain();

    // R10 overflow
    wr(4'h0, 16'h1000);
    for (int i = 0; i < 17; i++) conv(0);
    rd(4'h2, s);
    check(s == 16'h200C, "R10 full and overflow", s, 16'h200C);
    rd(4'h2, s);
    check(s == 16'h0004, "R10 overflow cleared", s, 16'h0004);
    for (int i = 0; i < 16; i++) fifo_expect(0, "R10 kept samples");
    rd(4'h2, s);
    check(s == 16'h0002, "R9 empty after drain", s, 16'h0002);

    // R11 eoc interrupt
    wr(4'hE, 16'h0001);
    wr(4'h0, 16'h1404);
    conv(4);
    check(irq == 1'b1, "R11 eoc irq", irq, 1);
    rd(4'h2, s);
    check(irq == 1'b0, "R11 eoc irq cleared", irq, 0);
    drain();

    // R13 back to idle
    wr(4'hE, 16'h0000);
    wr(4'h0, 16'h0000);
    rd(4'h2, s);
    tick_ignored("R13 idle ignores ticks");
    check(irq == 1'b0, "R13 idle irq", irq, 0);

    check(exp_q.size() == 0, "R4 all expected starts seen", exp_q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule